// File: doc/BRIEF.md
# Per-CPU Level-1 Interrupt Aggregator

The block gathers a wide vector of level-sensitive interrupt sources and distributes them to several CPUs. The sources are grouped into 32-bit words. Each CPU owns a bank of registers on a simple 32-bit read/write bus. For every word, a bank holds one plain read/write enable register and one read-only status register. Software enables a single source by reading the enable word, changing the bit, and writing the whole word back. No set or clear aliases exist.

Each CPU has its own interrupt line. The line is a registered OR over its bank of (status AND enable), so a CPU is only interrupted by sources that are both asserted and enabled in its own bank. One source can be enabled in one bank, in several banks or in none, independently. Inside each bank the word order is reversed, so the lowest address covers the highest-numbered sources.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every enable register reads zero, every `cpu_irq` bit is 0 and `rdata` is 0.
- R2: With NW words, the bank of CPU c starts at byte address c*8*NW. The enable register at byte offset 4*s (s < NW) controls word NW-1-s. The status register at byte offset 4*(NW+s) shows word NW-1-s. Word w bit i is source 32*w+i. Address bits [1:0] are ignored.
- R3: A write to an enable address stores all 32 bits of `wdata` at the clock edge where `wr_en` is high. A later read returns that value.
- R4: A status read returns the live level of the word's sources, sampled at the read edge. Writes to status addresses change no enable register and no output.
- R5: `cpu_irq[c]` is 1 exactly when, one clock earlier, some source was high and also enabled in bank c.
- R6: Enables are per CPU: the same source can be enabled in one bank and disabled in another, and only the enabling CPU's line follows it.
- R7: Addresses at or beyond N_CPUS*8*NW read as zero, and writes to them change no register.
- R8: `rdata` carries the read value in the cycle after `rd_en` is high, and is zero in a cycle that follows a cycle without `rd_en`.
- R9: When a read and a write hit the same enable address in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | 32*NW | Level of each interrupt source, bit k is source k |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| cpu_irq | output | N_CPUS | Per-CPU combined interrupt line |

## Verification
The hardest case to reach from the ports is a stale or misrouted enable that hides behind the reversed word order. An enable that lands in the wrong word, or in the wrong CPU's bank, still reads back correctly if the bench decodes the addresses the same wrong way. The stimulus therefore pairs every enable write with a status read and an interrupt check that reach the source from the other side of the map: a single source is driven in one word, and the bench confirms which CPU line rises. A separate sweep writes every out-of-range address and every status address with all ones, then reads back every enable register to confirm nothing moved.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
  localparam int unsigned SRC_PER_WORD = 32;
  localparam int unsigned REG_BYTES    = 4;

  // index width with a floor of one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // register slots (enable + status) per CPU bank
  function automatic int unsigned bank_slots(input int unsigned nw);
    return 2 * nw;
  endfunction

  // slot inside a group -> logical word number (reversed order)
  function automatic int unsigned flip_word(input int unsigned grp,
                                            input int unsigned nw);
    return nw - 1 - grp;
  endfunction
endpackage

// File: rtl/irqagg_decode.sv
`timescale 1ns/1ps
module irqagg_decode
  import irqagg_pkg::*;
#(
  parameter int unsigned NW     = 4,
  parameter int unsigned N_CPUS = 2,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CPU_W = idx_w(N_CPUS),
  localparam int unsigned WD_W  = idx_w(NW)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CPU_W-1:0]  cpu_idx,
  output logic              is_status,
  output logic [WD_W-1:0]   word_idx
);
  localparam int unsigned SLOTS = bank_slots(NW);
  localparam int unsigned LIMIT = N_CPUS * SLOTS;

  int unsigned slot, rem, grp;

  always_comb begin
    slot      = int'(addr[ADDR_W-1:2]);
    hit       = slot < LIMIT;
    rem       = slot % SLOTS;
    is_status = rem >= NW;
    grp       = is_status ? rem - NW : rem;
    cpu_idx   = CPU_W'(slot / SLOTS);
    word_idx  = WD_W'(flip_word(grp, NW));
  end
endmodule

// File: rtl/irqagg_bank.sv
`timescale 1ns/1ps
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int unsigned NW = 4,
  localparam int unsigned WD_W  = idx_w(NW),
  localparam int unsigned SRC_W = NW * SRC_PER_WORD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic             wr_en,
  input  logic             sel,
  input  logic             is_status,
  input  logic [WD_W-1:0]  word_idx,
  input  logic [31:0]      wdata,
  output logic [SRC_W-1:0] en_flat,
  output logic             irq_o
);
  logic pend_any;

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [31:0] en_q;
    logic        w_hit;
    assign w_hit = wr_en && sel && !is_status && (word_idx == WD_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (w_hit) en_q <= wdata;
    end
    assign en_flat[w*SRC_PER_WORD +: SRC_PER_WORD] = en_q;
  end

  assign pend_any = |(src & en_flat);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend_any;
  end

  AST_EN_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_flat == '0) |=> !irq_o); // R5
  AST_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel) |=> $stable(en_flat)); // R7
  AST_STATUS_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && is_status) |=> $stable(en_flat)); // R4
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned NW     = 4,
  parameter int unsigned N_CPUS = 2,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CPU_W = idx_w(N_CPUS),
  localparam int unsigned WD_W  = idx_w(NW),
  localparam int unsigned SRC_W = NW * SRC_PER_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_level,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [N_CPUS-1:0] cpu_irq
);
  logic             dec_hit;
  logic [CPU_W-1:0] dec_cpu;
  logic             dec_status;
  logic [WD_W-1:0]  dec_word;
  logic [SRC_W-1:0] en_all [N_CPUS];
  logic [N_CPUS-1:0] bank_sel;
  logic [31:0]      rd_word;

  irqagg_decode #(.NW(NW), .N_CPUS(N_CPUS), .ADDR_W(ADDR_W)) u_dec (
    .addr      (addr),
    .hit       (dec_hit),
    .cpu_idx   (dec_cpu),
    .is_status (dec_status),
    .word_idx  (dec_word)
  );

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    assign bank_sel[c] = dec_hit && (dec_cpu == CPU_W'(c));
    irqagg_bank #(.NW(NW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src_level),
      .wr_en     (wr_en),
      .sel       (bank_sel[c]),
      .is_status (dec_status),
      .word_idx  (dec_word),
      .wdata     (wdata),
      .en_flat   (en_all[c]),
      .irq_o     (cpu_irq[c])
    );
  end

  always_comb begin
    rd_word = '0;
    if (dec_hit) begin
      if (dec_status) rd_word = src_level[dec_word*SRC_PER_WORD +: SRC_PER_WORD];
      else            rd_word = en_all[dec_cpu][dec_word*SRC_PER_WORD +: SRC_PER_WORD];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
    else            rdata <= '0;
  end

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !dec_hit) |=> (rdata == '0)); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0)); // R8
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq != '0) |-> $past(|src_level)); // R5
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel)); // R6
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  localparam int NW = 4;
  localparam int NC = 2;
  localparam int SW = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] src_level = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] cpu_irq;

  int n_run = 0, n_fail = 0;
  logic [31:0] en_m [NC][NW];

  always #4 clk = ~clk;

  irq_aggregator dut (.clk(clk), .rst_n(rst_n), .src_level(src_level),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cpu_irq(cpu_irq));

  typedef struct packed {
    logic [SW-1:0] src;
    logic          wr;
    logic [7:0]    waddr;
    logic [31:0]   wd;
    logic [7:0]    raddr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{128'h0,                1'b1, 8'h00, 32'h8000_0001, 8'h00},
    '{{32'h1, 96'h0},        1'b0, 8'h00, 32'h0,         8'h10},
    '{128'h1,                1'b1, 8'h0C, 32'h0000_0001, 8'h1C},
    '{{64'h0, 32'h30, 32'h0},1'b1, 8'h24, 32'h0000_00F0, 8'h34},
    '{128'h1,                1'b1, 8'h2C, 32'hFFFF_FFFF, 8'h2C},
    '{128'h0,                1'b1, 8'h00, 32'h0,         8'h00},
    '{{32'h0, 96'h5},        1'b1, 8'h18, 32'hFFFF_FFFF, 8'h18},
    '{{SW{1'b1}},            1'b1, 8'h44, 32'hFFFF_FFFF, 8'h44},
    '{128'h0,                1'b1, 8'h05, 32'h0000_1234, 8'h04},
    '{{SW{1'b1}},            1'b0, 8'h00, 32'h0,         8'h3C}
  };

  // model: bank c covers bytes [c*8*NW, (c+1)*8*NW); enables first, reversed
  function automatic logic [31:0] ref_read(input logic [7:0] a);
    int slot = int'(a) / 4;
    for (int c = 0; c < NC; c++) begin
      int first = c * 2 * NW;
      if (slot >= first && slot < first + NW)
        return en_m[c][NW - 1 - (slot - first)];
      if (slot >= first + NW && slot < first + 2 * NW)
        return src_level[(NW - 1 - (slot - first - NW)) * 32 +: 32];
    end
    return 32'h0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int slot = int'(a) / 4;
    for (int c = 0; c < NC; c++)
      if (slot >= c * 2 * NW && slot < c * 2 * NW + NW)
        en_m[c][NW - 1 - (slot - c * 2 * NW)] = d;
  endtask

  function automatic logic [NC-1:0] ref_irq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if ((src_level[w*32 +: 32] & en_m[c][w]) != 0) r[c] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) en_m[c][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 irq", {30'h0, cpu_irq}, 32'h0);
    for (int a = 0; a < 8 * NW * NC; a += 8) begin
      do_read(8'(a), v);
      check("R1 enable", v, ref_read(8'(a)));
    end

    // table walk: R2 map/reversal, R3 RW, R4 status, R5 irq, R7 out of range
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); src_level = TBL[i].src;
      if (TBL[i].wr) do_write(TBL[i].waddr, TBL[i].wd);
      do_read(TBL[i].raddr, v);
      check($sformatf("R2/R3/R4 row%0d rdata", i), v, ref_read(TBL[i].raddr));
      check($sformatf("R5 row%0d irq", i), {30'h0, cpu_irq}, {30'h0, ref_irq()});
    end

    // R8: idle cycle gives zero
    @(negedge clk);
    check("R8 idle rdata", rdata, 32'h0);

    // R9: read and write same enable address together return old value
    do_write(8'h08, 32'hAAAA_5555);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 8'h08; wdata = 32'h1111_2222;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R9 old value", rdata, 32'hAAAA_5555);
    model_write(8'h08, 32'h1111_2222);
    do_read(8'h08, v);
    check("R9 new value", v, 32'h1111_2222);

    // R6: same source in both banks, then only cpu1 keeps it
    @(negedge clk); src_level = '0; src_level[SW-1] = 1'b1;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NW; s++) do_write(8'(c * 8 * NW + 4 * s), 32'h0);
    do_write(8'h00, 32'h8000_0000);
    do_write(8'h20, 32'h8000_0000);
    @(negedge clk);
    check("R6 both", {30'h0, cpu_irq}, 32'h3);
    do_write(8'h00, 32'h0);
    @(negedge clk);
    check("R6 cpu1 only", {30'h0, cpu_irq}, 32'h2);

    // R4/R7 sweep: status and out-of-range writes change nothing
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NW; s++) do_write(8'(c * 8 * NW + 4 * s), 32'h0100_0000 << s);
    for (int a = 8 * NW * NC; a < 256; a += 4) do_write(8'(a), 32'hFFFF_FFFF);
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NW; s++) do_write(8'(c * 8 * NW + 4 * (NW + s)), 32'hFFFF_FFFF);
    for (int a = 0; a < 8 * NW * NC; a += 4) begin
      do_read(8'(a), v);
      check("R4/R7 sweep", v, ref_read(8'(a)));
    end
    do_read(8'hF0, v);
    check("R7 far read", v, 32'h0);
    @(negedge clk);
    check("R5 after sweep", {30'h0, cpu_irq}, {30'h0, ref_irq()});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule